// File: doc/BRIEF.md
# Bit-Granular Copy Engine

This engine moves an arbitrary run of bits from one byte-addressed memory to another. The source run and the destination run may each begin at any bit position, so neither end need be byte aligned. Source bytes are fetched one at a time and shifted into an accumulator that lines them up with the destination. Each destination byte is then written out. A destination byte that the copy covers only in part is read first, merged under a mask, and written back, so the bits around the copied run keep their values.

A request is one `start` pulse carrying a source bit address, a destination bit address and a bit count. A bit address holds a byte index in its upper bits and a bit-within-byte in its low three bits. `busy` stays high while the copy runs and `done` pulses once at the end. Both memories are reached through valid/ready request channels. Once the engine raises a request valid, it holds the address, write flag and write data unchanged until it sees ready in the same cycle. The engine keeps at most one request outstanding across both memories. Read data returns on a response channel with a valid strobe and no ready: the responder may take any number of cycles, and the engine always accepts the response. The source and destination regions must not overlap.

Top module: `bit_copy_engine`

## Requirements
- R1: After reset, `busy`, `done`, `src_req_valid` and `dst_req_valid` are all low.
- R2: A bit address `a` names bit `a[2:0]` (counted from the least significant bit) of byte `a >> 3`. For every k below the count, destination bit `dst_bit_off + k` takes the value of source bit `src_bit_off + k`, and the engine writes each destination byte that holds a copied bit exactly once.
- R3: In the first destination byte, the bits below `dst_bit_off[2:0]` keep their earlier values.
- R4: In the last destination byte, the bits above the last copied bit keep their earlier values, and no byte outside the covered range is changed.
- R5: A request with a bit count of zero makes no memory request. It pulses `done` in the cycle after `start`, and `busy` stays low throughout.
- R6: The engine reads a destination byte only when the copy covers it in part. A byte covered in full, which includes every byte of a copy with both offsets byte aligned, is written without being read.
- R7: `done` is high for exactly one cycle, in the cycle right after the handshake of the final destination write. `busy` is low from that cycle on.
- R8: A `start` that arrives while `busy` is high is ignored: it does not change the copy in progress and does not start a new one.
- R9: A request held under back-pressure keeps its valid, address, write flag and write data stable until accepted. The source and destination request valids are never high together.
- R10: The engine fetches each source byte that holds a copied bit exactly once, in ascending order, and fetches no other source byte. A copy therefore makes `ceil((src_bit_off[2:0] + count) / 8)` source reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, sampled while idle |
| src_bit_off | input | ADDR_W+3 | Source start bit address |
| dst_bit_off | input | ADDR_W+3 | Destination start bit address |
| bit_count | input | CNT_W | Number of bits to copy |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| src_req_valid | output | 1 | Source read request valid |
| src_req_ready | input | 1 | Source read request accepted |
| src_req_addr | output | ADDR_W | Source byte address |
| src_rsp_valid | input | 1 | Source read data valid |
| src_rsp_data | input | 8 | Source read data |
| dst_req_valid | output | 1 | Destination request valid |
| dst_req_ready | input | 1 | Destination request accepted |
| dst_req_write | output | 1 | 1 = write, 0 = read |
| dst_req_addr | output | ADDR_W | Destination byte address |
| dst_req_wdata | output | 8 | Destination write data |
| dst_rsp_valid | input | 1 | Destination read data valid |
| dst_rsp_data | input | 8 | Destination read data |

## Verification
Two events can land in the same cycle: the handshake of the final destination write, which ends the copy, and a new `start` pulse. To provoke this, the bench holds `start` high with a second, different request for the whole of a copy, including the edge that accepts the last write, and drops it only once `done` is seen. The second request must leave no trace. The bench judges this from the destination write count, from memory contents that match the first request alone, and from `busy` staying low after `done`. Around this case, a sweep over every pair of source and destination bit phases and every count from 0 to 24 runs under random ready and response delays. Each copy is compared bit by bit with a reference computed arithmetically.

// File: rtl/bc_pkg.sv
package bc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PLAN,
    ST_FETCH,
    ST_FWAIT,
    ST_DREAD,
    ST_DWAIT,
    ST_WRITE
  } bc_state_e;

  // mask with the low n bits set, n in 0..8
  function automatic logic [7:0] low_ones(input logic [3:0] n);
    logic [8:0] wide;
    wide = (9'd1 << n) - 9'd1;
    return wide[7:0];
  endfunction

endpackage

// File: rtl/bc_offset_split.sv
module bc_offset_split #(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W+2:0] bit_addr,
  output logic [ADDR_W-1:0] byte_idx,
  output logic [2:0]        bit_idx
);
  assign byte_idx = bit_addr[ADDR_W+2:3];
  assign bit_idx  = bit_addr[2:0];
endmodule

// File: rtl/bc_shift_acc.sv
module bc_shift_acc #(
  parameter int ACC_W = 16,
  localparam int CW = $clog2(ACC_W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic [7:0]    push_data,
  input  logic [2:0]    push_skip,
  input  logic          pop,
  input  logic [3:0]    pop_n,
  output logic [7:0]    acc_lo,
  output logic [CW-1:0] cnt
);
  logic [ACC_W-1:0] acc;
  logic [7:0]       aligned;
  logic [3:0]       gained;

  assign aligned = push_data >> push_skip;
  assign gained  = 4'd8 - {1'b0, push_skip};
  assign acc_lo  = acc[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      cnt <= '0;
    end else if (clear) begin
      acc <= '0;
      cnt <= '0;
    end else if (pop) begin
      acc <= acc >> pop_n;
      cnt <= cnt - CW'(pop_n);
    end else if (push) begin
      acc <= acc | (ACC_W'(aligned) << cnt);
      cnt <= cnt + CW'(gained);
    end
  end

  // R2: a push never overflows the accumulator
  p_acc_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (32'(cnt) + 8 <= ACC_W));

  // R2: a pop never takes more bits than are held
  p_pop_avail_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (32'(pop_n) <= 32'(cnt)));
endmodule

// File: rtl/bc_merge.sv
module bc_merge
  import bc_pkg::*;
(
  input  logic [7:0] old_byte,
  input  logic [7:0] new_bits,
  input  logic [2:0] lsb,
  input  logic [3:0] nbits,
  output logic [7:0] merged
);
  logic [7:0] mask;
  assign mask   = low_ones(nbits) << lsb;
  assign merged = (old_byte & ~mask) | ((new_bits << lsb) & mask);
endmodule

// File: rtl/bit_copy_engine.sv
module bit_copy_engine
  import bc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 12,
  parameter int ACC_W  = 16,
  localparam int OFF_W = ADDR_W + 3,
  localparam int CW    = $clog2(ACC_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OFF_W-1:0]  src_bit_off,
  input  logic [OFF_W-1:0]  dst_bit_off,
  input  logic [CNT_W-1:0]  bit_count,
  output logic              busy,
  output logic              done,
  output logic              src_req_valid,
  input  logic              src_req_ready,
  output logic [ADDR_W-1:0] src_req_addr,
  input  logic              src_rsp_valid,
  input  logic [7:0]        src_rsp_data,
  output logic              dst_req_valid,
  input  logic              dst_req_ready,
  output logic              dst_req_write,
  output logic [ADDR_W-1:0] dst_req_addr,
  output logic [7:0]        dst_req_wdata,
  input  logic              dst_rsp_valid,
  input  logic [7:0]        dst_rsp_data
);
  bc_state_e         state;
  logic [ADDR_W-1:0] src_addr, dst_addr;
  logic [2:0]        src_skip, dst_lsb;
  logic [CNT_W-1:0]  rem;
  logic [7:0]        wbuf;
  logic              done_q;

  logic [ADDR_W-1:0] s_byte, d_byte;
  logic [2:0]        s_bit, d_bit;

  logic [3:0]        room, take;
  logic [7:0]        acc_lo, merged;
  logic [CW-1:0]     acc_cnt;
  logic              acc_clear, acc_push, acc_pop, accept;

  bc_offset_split #(.ADDR_W(ADDR_W)) u_src_split (
    .bit_addr(src_bit_off), .byte_idx(s_byte), .bit_idx(s_bit));
  bc_offset_split #(.ADDR_W(ADDR_W)) u_dst_split (
    .bit_addr(dst_bit_off), .byte_idx(d_byte), .bit_idx(d_bit));

  // bits the current destination byte can take
  assign room = 4'd8 - {1'b0, dst_lsb};
  assign take = (rem < {{(CNT_W-4){1'b0}}, room}) ? rem[3:0] : room;

  assign accept    = (state == ST_IDLE) && start;
  assign acc_clear = accept;
  assign acc_push  = (state == ST_FWAIT) && src_rsp_valid;
  assign acc_pop   = (state == ST_WRITE) && dst_req_ready;

  bc_shift_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(acc_clear),
    .push(acc_push), .push_data(src_rsp_data), .push_skip(src_skip),
    .pop(acc_pop), .pop_n(take), .acc_lo(acc_lo), .cnt(acc_cnt));

  bc_merge u_merge (
    .old_byte(dst_rsp_data), .new_bits(acc_lo), .lsb(dst_lsb),
    .nbits(take), .merged(merged));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      src_addr <= '0;
      dst_addr <= '0;
      src_skip <= '0;
      dst_lsb  <= '0;
      rem      <= '0;
      wbuf     <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (bit_count == '0) begin
              done_q <= 1'b1;
            end else begin
              src_addr <= s_byte;
              src_skip <= s_bit;
              dst_addr <= d_byte;
              dst_lsb  <= d_bit;
              rem      <= bit_count;
              state    <= ST_PLAN;
            end
          end
        end
        ST_PLAN: begin
          if (acc_cnt < CW'(take)) begin
            state <= ST_FETCH;
          end else if (take == 4'd8) begin
            wbuf  <= acc_lo;
            state <= ST_WRITE;
          end else begin
            state <= ST_DREAD;
          end
        end
        ST_FETCH: if (src_req_ready) state <= ST_FWAIT;
        ST_FWAIT: begin
          if (src_rsp_valid) begin
            src_addr <= src_addr + 1'b1;
            src_skip <= '0;
            state    <= ST_PLAN;
          end
        end
        ST_DREAD: if (dst_req_ready) state <= ST_DWAIT;
        ST_DWAIT: begin
          if (dst_rsp_valid) begin
            wbuf  <= merged;
            state <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (dst_req_ready) begin
            rem      <= rem - {{(CNT_W-4){1'b0}}, take};
            dst_addr <= dst_addr + 1'b1;
            dst_lsb  <= '0;
            if (rem == {{(CNT_W-4){1'b0}}, take}) begin
              done_q <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              state <= ST_PLAN;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy          = (state != ST_IDLE);
  assign done          = done_q;
  assign src_req_valid = (state == ST_FETCH);
  assign src_req_addr  = src_addr;
  assign dst_req_valid = (state == ST_DREAD) || (state == ST_WRITE);
  assign dst_req_write = (state == ST_WRITE);
  assign dst_req_addr  = dst_addr;
  assign dst_req_wdata = wbuf;

  p_src_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req_valid && !src_req_ready) |=> (src_req_valid && $stable(src_req_addr)));

  p_dst_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_req_valid && !dst_req_ready) |=> (dst_req_valid && $stable(dst_req_addr)
      && $stable(dst_req_write) && $stable(dst_req_wdata)));

  p_one_port_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_req_valid && dst_req_valid));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_at_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_last_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_req_valid && dst_req_write && dst_req_ready && rem == {{(CNT_W-4){1'b0}}, take})
      |=> done);

  p_zero_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && bit_count == '0) |=> (done && !busy));

  p_busy_ignores_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !(dst_req_valid && dst_req_write && dst_req_ready
      && rem == {{(CNT_W-4){1'b0}}, take})) |=> busy);
endmodule

// File: tb/test_bit_copy_engine.sv
module test_bit_copy_engine;
  localparam int ADDR_W = 8;
  localparam int CNT_W  = 12;
  localparam int OFF_W  = ADDR_W + 3;
  localparam int MEM    = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [OFF_W-1:0] src_bit_off = '0, dst_bit_off = '0;
  logic [CNT_W-1:0] bit_count = '0;
  logic busy, done;
  logic src_req_valid, dst_req_valid, dst_req_write;
  logic [ADDR_W-1:0] src_req_addr, dst_req_addr;
  logic [7:0] dst_req_wdata;
  logic s_ready, d_ready, s_rvalid, d_rvalid;
  logic [7:0] s_rdata, d_rdata;

  always #4 clk = ~clk;

  bit_copy_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .ACC_W(16)) i_bit_copy_engine (
    .clk(clk), .rst_n(rst_n), .start(start),
    .src_bit_off(src_bit_off), .dst_bit_off(dst_bit_off), .bit_count(bit_count),
    .busy(busy), .done(done),
    .src_req_valid(src_req_valid), .src_req_ready(s_ready), .src_req_addr(src_req_addr),
    .src_rsp_valid(s_rvalid), .src_rsp_data(s_rdata),
    .dst_req_valid(dst_req_valid), .dst_req_ready(d_ready), .dst_req_write(dst_req_write),
    .dst_req_addr(dst_req_addr), .dst_req_wdata(dst_req_wdata),
    .dst_rsp_valid(d_rvalid), .dst_rsp_data(d_rdata));

  function automatic logic [7:0] pat_s(input int seed, input int i);
    logic [15:0] x;
    x = 16'(seed * 40503 + i * 2654 + i * i * 97 + 13);
    return x[11:4] ^ x[15:8];
  endfunction

  function automatic logic [7:0] pat_d(input int seed, input int i);
    logic [15:0] x;
    x = 16'(seed * 31337 + i * 7919 + i * i * 53 + 71);
    return x[12:5] ^ x[7:0];
  endfunction

  // memory model, activity counters
  logic [7:0]  smem [MEM];
  logic [7:0]  dmem [MEM];
  logic [15:0] lfsr;
  logic        load_go = 1'b0;
  int          load_seed = 0;
  logic        s_pend, d_pend;
  logic [1:0]  s_lat, d_lat;
  int cyc, n_src_rd, n_dst_rd, n_dst_wr, n_done, last_wr_cyc, done_cyc;
  logic busy_seen;

  always @(posedge clk) begin
    lfsr    <= (lfsr == 16'd0) ? 16'hACE1 : {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    s_ready <= lfsr[0] | lfsr[5];
    d_ready <= lfsr[2] | lfsr[9];
    cyc     <= cyc + 1;
    s_rvalid <= 1'b0;
    d_rvalid <= 1'b0;
    if (load_go) begin
      for (int i = 0; i < MEM; i++) begin
        smem[i] <= pat_s(load_seed, i);
        dmem[i] <= pat_d(load_seed, i);
      end
      n_src_rd <= 0; n_dst_rd <= 0; n_dst_wr <= 0; n_done <= 0;
      last_wr_cyc <= -10; done_cyc <= -20; busy_seen <= 1'b0;
    end else begin
      if (busy) busy_seen <= 1'b1;
      if (done) begin n_done <= n_done + 1; done_cyc <= cyc; end
      if (src_req_valid && s_ready) begin
        s_pend <= 1'b1; s_lat <= lfsr[4:3];
        s_rdata <= smem[src_req_addr[5:0]];
        n_src_rd <= n_src_rd + 1;
      end else if (s_pend) begin
        if (s_lat == 2'd0) begin s_rvalid <= 1'b1; s_pend <= 1'b0; end
        else s_lat <= s_lat - 2'd1;
      end
      if (dst_req_valid && d_ready) begin
        if (dst_req_write) begin
          dmem[dst_req_addr[5:0]] <= dst_req_wdata;
          n_dst_wr <= n_dst_wr + 1;
          last_wr_cyc <= cyc;
        end else begin
          d_pend <= 1'b1; d_lat <= lfsr[8:7];
          d_rdata <= dmem[dst_req_addr[5:0]];
          n_dst_rd <= n_dst_rd + 1;
        end
      end else if (d_pend) begin
        if (d_lat == 2'd0) begin d_rvalid <= 1'b1; d_pend <= 1'b0; end
        else d_lat <= d_lat - 2'd1;
      end
    end
  end

  initial begin
    lfsr = 16'hACE1; s_pend = 0; d_pend = 0; s_lat = 0; d_lat = 0;
    s_ready = 0; d_ready = 0; s_rvalid = 0; d_rvalid = 0; s_rdata = 0; d_rdata = 0;
    cyc = 0; n_src_rd = 0; n_dst_rd = 0; n_dst_wr = 0; n_done = 0;
    last_wr_cyc = -10; done_cyc = -20; busy_seen = 0;
  end

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  task automatic chk(input string tag, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic run_copy(input int so, input int dq, input int cnt, input int seed,
                          input bit stray);
    logic [7:0] emem [MEM];
    int fb, lb, exp_rd, exp_src, guard;
    int g2, e2, g3, e3, g4, e4;
    bit m2, m3, m4;
    @(negedge clk);
    load_seed = seed; load_go = 1'b1;
    @(negedge clk);
    load_go = 1'b0;
    start = 1'b1;
    src_bit_off = OFF_W'(so); dst_bit_off = OFF_W'(dq); bit_count = CNT_W'(cnt);
    @(negedge clk);
    start = 1'b0;
    if (stray) begin
      // second request held high for the whole copy (R8)
      start = 1'b1; src_bit_off = OFF_W'(3); dst_bit_off = OFF_W'(40 * 8 + 5);
      bit_count = CNT_W'(37);
    end
    guard = 0;
    while (!done && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    start = 1'b0;
    if (guard >= 3000) chk("R7 watchdog: copy never finished", 0, 1);
    repeat (3) @(negedge clk);

    for (int i = 0; i < MEM; i++) emem[i] = pat_d(seed, i);
    for (int k = 0; k < cnt; k++) begin
      int sp, dp;
      logic [7:0] sb;
      sp = so + k; dp = dq + k;
      sb = pat_s(seed, sp >> 3);
      emem[dp >> 3][dp & 7] = sb[sp & 7];
    end
    fb = dq >> 3;
    lb = (cnt > 0) ? (dq + cnt - 1) >> 3 : fb - 1;
    m2 = 0; m3 = 0; m4 = 0; g2 = 0; e2 = 0; g3 = 0; e3 = 0; g4 = 0; e4 = 0;
    for (int i = 0; i < MEM; i++) begin
      if (dmem[i] !== emem[i]) begin
        if (cnt > 0 && i == fb && (dq & 7) != 0) begin
          if (!m3) begin g3 = int'(dmem[i]); e3 = int'(emem[i]); end
          m3 = 1;
        end else if (i < fb || i > lb || (i == lb && ((dq + cnt) & 7) != 0)) begin
          if (!m4) begin g4 = int'(dmem[i]); e4 = int'(emem[i]); end
          m4 = 1;
        end else begin
          if (!m2) begin g2 = int'(dmem[i]); e2 = int'(emem[i]); end
          m2 = 1;
        end
      end
    end
    chk("R2 copied byte", g2, e2);
    chk("R3 first byte low bits", g3, e3);
    chk("R4 tail bits and outside bytes", g4, e4);

    if (cnt == 0) begin
      chk("R5 writes for zero count", n_dst_wr, 0);
      chk("R5 reads for zero count", n_src_rd + n_dst_rd, 0);
      chk("R5 busy seen for zero count", int'(busy_seen), 0);
      chk("R5 done pulses", n_done, 1);
    end else begin
      exp_src = ((so & 7) + cnt + 7) / 8;
      if (fb == lb)
        exp_rd = ((dq & 7) != 0 || ((dq + cnt) & 7) != 0) ? 1 : 0;
      else
        exp_rd = (((dq & 7) != 0) ? 1 : 0) + ((((dq + cnt) & 7) != 0) ? 1 : 0);
      chk("R10 source reads", n_src_rd, exp_src);
      chk("R6 destination reads", n_dst_rd, exp_rd);
      chk(stray ? "R8 writes with stray start" : "R2 destination writes",
          n_dst_wr, lb - fb + 1);
      chk("R7 done pulses", n_done, 1);
      chk("R7 done one cycle after last write", done_cyc - last_wr_cyc, 1);
    end
    chk("R7 busy low after done", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy at reset", int'(busy), 0);
    chk("R1 done at reset", int'(done), 0);
    chk("R1 request valids at reset", int'(src_req_valid) + int'(dst_req_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int sb = 0; sb < 8; sb++)
      for (int db = 0; db < 8; db++)
        for (int c = 0; c <= 24; c++)
          run_copy(((sb + c) % 3) * 8 + sb, ((db * 3 + c) % 4) * 8 + db, c,
                   sb * 211 + db * 37 + c, 1'b0);

    // long runs, both aligned and unaligned (R6)
    for (int v = 0; v < 8; v++)
      run_copy(v * 3, 64 + v * 5, 200 - v * 9, 900 + v, 1'b0);
    run_copy(16, 64, 160, 77, 1'b0);

    // start held high across the final write and dropped at done (R8)
    for (int v = 0; v < 6; v++)
      run_copy(v + 1, 8 + v * 3, 9 + v * 7, 500 + v, 1'b1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: got %0d cycles expected fewer", 195000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule